// File: doc/BRIEF.md
# Periodic Output Impedance Calibrator

This block is a digital controller that keeps the drive-strength code of an output driver close to its optimum. The optimum impedance is one fifth of an external reference resistor. That resistor may lie anywhere from 175 to 350 ohms, so the code range must reach targets from 35 to 70 ohms. An analog comparator, which is outside this block, compares the driver against the reference and supplies a single decision bit. The controller reads that bit only at evaluations, and a free-running cycle counter triggers those evaluations at a fixed interval.

At each evaluation the code moves by one step toward the optimum, or it stays where it is. The counter then starts again from zero. Because the code changes at most once per interval and only by one step, the driver strength never jumps. Repeating the evaluations tracks slow drift in supply voltage and temperature. A dead-band input lets the comparator logic report that the impedance is already within tolerance, and then the code is held. A one-cycle strobe marks every evaluation.

A larger code means more active driver legs, and so a lower impedance.

Top module: `imp_cal`

## Requirements
- R1: While reset is active and in the first cycle after it, `code` equals the mid-range value 2^(CODE_W-1) and `upd` is 0.
- R2: `upd` is a one-cycle pulse. It first rises INTERVAL cycles after reset is released, and after that it recurs exactly every INTERVAL cycles, whatever the inputs do.
- R3: `code` changes only on the clock edge that raises `upd`, and never by more than one step.
- R4: At an evaluation with `in_band`=0 and `cmp_high`=1 (impedance too high), `code` increases by one.
- R5: At an evaluation with `in_band`=0 and `cmp_high`=0 (impedance too low), `code` decreases by one.
- R6: At the maximum value 2^CODE_W-1, an upward request leaves `code` unchanged. It does not wrap.
- R7: At 0, a downward request leaves `code` unchanged. It does not wrap.
- R8: At an evaluation with `in_band`=1, `code` is held whatever `cmp_high` is, and `upd` still pulses.
- R9: Values of `cmp_high` and `in_band` between evaluations have no effect. Only the values present on the evaluating edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_high | input | 1 | Comparator decision: 1 means impedance too high, 0 means too low |
| in_band | input | 1 | 1 means impedance is within tolerance, so hold the code |
| code | output | CODE_W | Driver impedance code; larger means stronger drive |
| upd | output | 1 | One-cycle strobe marking each evaluation |

## Verification
The bench builds the block with CODE_W=4 and INTERVAL=8. This gives 16 codes with a mid-range start of 8. Both saturation limits can then be reached within a few dozen evaluations, and the strobe spacing can be measured cycle by cycle over many intervals. The short interval also leaves room to toggle the comparator and dead-band inputs between evaluations, which exposes any update made off the strobe.

// File: rtl/imp_cal.sv
module imp_cal #(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_high,
  input  logic              in_band,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt;
  logic fire, at_top, at_bot;

  assign fire   = (cnt == CNT_END);
  assign at_top = (code == CODE_TOP);
  assign at_bot = (code == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      upd <= 1'b0;
    end else begin
      cnt <= fire ? '0 : cnt + 1'b1;
      upd <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      code <= CODE_MID;
    else if (fire && !in_band) begin
      if (cmp_high && !at_top)
        code <= code + 1'b1;
      else if (!cmp_high && !at_bot)
        code <= code - 1'b1;
    end
  end
endmodule

// File: rtl/imp_cal_chk.sv
module imp_cal_chk #(
  parameter int CODE_W   = 6,
  parameter int INTERVAL = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_high,
  input logic              in_band,
  input logic [CODE_W-1:0] code,
  input logic              upd
);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
  int unsigned gap;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= 0;
    else        gap <= upd ? 1 : gap + 1;
  end

  AST_STROBE_SPACING: assert property (@(posedge clk) disable iff (!rst_n) upd |-> gap == INTERVAL); // R2
  AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) gap <= INTERVAL); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) upd |=> !upd); // R2
  AST_QUIET_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n) !upd |-> $stable(code)); // R3
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (code == $past(code)) || (code == $past(code) + 1'b1) || (code == $past(code) - 1'b1)); // R3
  AST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !$past(in_band) && $past(cmp_high) && $past(code) != CODE_TOP) |-> code == $past(code) + 1'b1); // R4
  AST_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !$past(in_band) && !$past(cmp_high) && $past(code) != '0) |-> code == $past(code) - 1'b1); // R5
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == CODE_TOP && $past(cmp_high)) |-> code == CODE_TOP); // R6
  AST_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == '0 && !$past(cmp_high)) |-> code == '0); // R7
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(in_band) |-> $stable(code)); // R8
endmodule

bind imp_cal imp_cal_chk #(.CODE_W(CODE_W), .INTERVAL(INTERVAL)) u_chk (.*);

// File: tb/sim_imp_cal.sv
`timescale 1ns/1ps
module sim_imp_cal;
  localparam int W = 4;
  localparam int IV = 8;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cmp_high = 1'b0, in_band = 1'b0;
  logic [W-1:0] code;
  logic upd;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  imp_cal #(.CODE_W(W), .INTERVAL(IV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmp_high(cmp_high), .in_band(in_band), .code(code), .upd(upd));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for the next strobe and returns the number of cycles waited.
  // Checks that code stays put on every non-strobe cycle (R3).
  task automatic wait_upd(output int n);
    int last = code;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!upd) chk("R3 code stable off strobe", code, last);
    end while (!upd && n < 4 * IV);
  endtask

  task automatic eval(input logic c, input logic b, input int exp, input string req);
    int n;
    cmp_high = c; in_band = b;
    wait_upd(n);
    chk(req, code, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 code in reset", code, 1 << (W - 1));
    chk("R1 upd in reset", upd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code after release", code, 1 << (W - 1));
    chk("R1 upd after release", upd, 0);
  endtask

  task automatic t_strobe();
    int n;
    in_band = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    wait_upd(n);
    chk("R2 first strobe delay", n, IV);
    for (int i = 0; i < 5; i++) begin
      cmp_high = ~cmp_high;
      wait_upd(n);
      chk("R2 strobe period", n, IV);
    end
    @(negedge clk);
    chk("R2 strobe width", upd, 0);
  endtask

  task automatic t_up_sat();
    int exp = code;
    while (exp < TOP) begin
      exp++;
      eval(1'b1, 1'b0, exp, "R4 step up");
    end
    eval(1'b1, 1'b0, TOP, "R6 hold at top");
    eval(1'b1, 1'b0, TOP, "R6 hold at top again");
  endtask

  task automatic t_down_sat();
    int exp = code;
    while (exp > 0) begin
      exp--;
      eval(1'b0, 1'b0, exp, "R5 step down");
    end
    eval(1'b0, 1'b0, 0, "R7 hold at bottom");
    eval(1'b0, 1'b0, 0, "R7 hold at bottom again");
  endtask

  task automatic t_band();
    int c0 = code;
    eval(1'b1, 1'b1, c0, "R8 band hold up");
    eval(1'b0, 1'b1, c0, "R8 band hold down");
  endtask

  task automatic t_ignore();
    int n, c0;
    wait_upd(n);
    c0 = code;
    for (int i = 0; i < IV - 2; i++) begin
      cmp_high = i[0];
      in_band = i[1];
      @(negedge clk);
      chk("R9 between evaluations", code, c0);
    end
    cmp_high = 1'b1; in_band = 1'b0;
    wait_upd(n);
    chk("R9 only evaluating edge counts", code, c0 + 1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_strobe();
    t_up_sat();
    t_down_sat();
    eval(1'b1, 1'b0, 1, "R4 step up from bottom");
    eval(1'b1, 1'b0, 2, "R4 step up again");
    t_band();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule